// File: doc/BRIEF.md
# Timer with Match Actions and Input Capture

A 16-bit up-counting timer with a bank of compare registers and a single input-capture channel. The counter advances once per clock while running (clock mode), or once per synchronized rising edge of an event input (event mode). Every compare register is checked against the counter in each cycle the timer runs. When the two are equal, the per-register action bits can set a sticky interrupt flag, send the counter back to zero, or stop the timer, in any combination.

The capture channel passes an external input through a two-flop synchronizer. It copies the counter into a capture register on a rising edge, a falling edge or both, as configured. It can also set its own sticky flag. In event mode the capture channel is held off entirely. Software reaches all of this through a flat word-addressed write port and a combinational read port. All flags are cleared by writing ones to the status word.

Register map (word addresses): 0x00 control, 0x01 counter (read only), 0x02 capture setup, 0x03 capture value (read only), 0x04 status, 0x10+i compare value i, 0x20+i action bits of compare i.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter, capture value, status, control, capture setup and every compare value and action word read 0, and `irq_o` is low.
- R2: A compare value occupies bits 15:0 of its word; a write stores only those bits and bits 31:16 read as zero.
- R3: When compare i has action bit 0 (interrupt) set and equals the counter while the timer runs, status bit i is 1 from the next clock edge, and `irq_o` is the OR of all status bits.
- R4: When compare i has action bit 2 (halt) set and equals the counter while running, control bit 0 (run) reads 0 from the next edge, and the counter holds the matched value.
- R5: When compare i has action bit 1 (clear) set and equals the counter while running, the counter is 0 from the next edge, so the matched value is visible for exactly one cycle. With clear and halt both set, the counter becomes 0 and the timer stops.
- R6: Actions of several compares that hit in the same cycle are combined (ORed).
- R7: With control bit 0 (run) set and control bit 1 (event mode) clear, the counter increments on every clock. In event mode it increments once per rising edge of `ev_in` and ignores the clock otherwise. With run clear it holds.
- R8: With capture setup bit 3 (enable) set, a synchronized 0-to-1 change of `cap_in` with bit 0 set, or a 1-to-0 change with bit 1 set, loads the capture value with the counter value of the cycle in which the edge is detected. That is the cycle after the second clock edge following the input change. Both bits set captures on every edge.
- R9: With capture setup bit 3 clear, no edge loads the capture value or sets the capture flag.
- R10: A capture load with capture setup bit 2 set sets status bit 4 (the bit just above the compare flags, for four compares); without bit 2 the flag stays clear.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it. A set and a clear in the same cycle leave the bit set.
- R12: In event mode no capture occurs, whatever the capture setup bits hold.
- R13: Writes to the counter and capture value addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| ev_in | input | 1 | External event input counted in event mode |
| cap_in | input | 1 | External capture input |
| irq_o | output | 1 | OR of all status flags |

## Verification
The bench aims at the one-cycle timing of match actions. It checks that a clearing compare shows its matched value for exactly one cycle and that a halting compare freezes the counter on that value. A design that acted one cycle early or late, or let the counter step past the match before stopping, would read a neighbouring count. Captures are checked against the counter read in the exact detection cycle, so an extra or missing synchronizer stage shows up as an off-by-one value. The bench also checks the wrong-edge, disabled-channel and event-mode cases, where a leaky gate would change the capture value. The set-versus-clear race on a flag is checked with a compare that hits every cycle: a clear-wins design would drop the flag.

// File: rtl/tmr_pkg.sv
// Shared register addresses and field layouts for the match/capture timer.
// Assumes word addressing; compare registers occupy two banks of up to 16.
package tmr_pkg;
    localparam int A_CTRL      = 0;
    localparam int A_COUNT     = 1;
    localparam int A_CAPCFG    = 2;
    localparam int A_CAPVAL    = 3;
    localparam int A_STATUS    = 4;
    localparam int A_MVAL_BASE = 16;
    localparam int A_MACT_BASE = 32;

    // Action bits of one compare: bit2 halt, bit1 clear, bit0 interrupt.
    typedef struct packed {
        logic halt;
        logic clr;
        logic irq;
    } match_act_t;

    // Capture setup: bit3 enable, bit2 flag enable, bit1 falling, bit0 rising.
    typedef struct packed {
        logic en;
        logic ie;
        logic fall;
        logic rise;
    } cap_cfg_t;
endpackage

// File: rtl/tmr_sync_edge.sv
// Synchronizes an asynchronous input into the clock domain and reports
// single-cycle rising and falling edge strobes. Assumes STAGES >= 2.
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    // Shift the input through the synchronizer and keep the last settled sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
            prev <= 1'b0;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            prev <= pipe[STAGES-1];
        end
    end

    assign rise = pipe[STAGES-1] & ~prev;
    assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/tmr_counter.sv
// The timer counter. Clear has priority over halt, halt over counting.
// Assumes clr_req and halt_req are only raised while the timer runs.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             evt_mode,
    input  logic             evt_rise,
    input  logic             clr_req,
    input  logic             halt_req,
    output logic [CNT_W-1:0] count
);
    logic step;

    // A step is one clock in clock mode or one input edge in event mode.
    always_comb step = run && (!evt_mode || evt_rise);

    // Advance, clear or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr_req) begin
            count <= '0;
        end else if (halt_req) begin
            count <= count;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_match_bank.sv
// Bank of compare registers with per-register action bits. Each compare
// raises its requests while the timer runs and its value equals the counter.
// Assumes write enables are one-hot per register.
module tmr_match_bank
    import tmr_pkg::*;
#(
    parameter int NUM_MATCH = 4,
    parameter int CNT_W     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_MATCH-1:0]            val_we,
    input  logic [NUM_MATCH-1:0]            act_we,
    input  logic [CNT_W-1:0]                wr_val,
    input  match_act_t                      wr_act,
    input  logic [CNT_W-1:0]                count,
    input  logic                            run,
    output logic [NUM_MATCH-1:0][CNT_W-1:0] val_q,
    output match_act_t [NUM_MATCH-1:0]      act_q,
    output logic [NUM_MATCH-1:0]            irq_set,
    output logic                            clr_req,
    output logic                            halt_req
);
    logic [NUM_MATCH-1:0] hit;
    logic [NUM_MATCH-1:0] clr_v;
    logic [NUM_MATCH-1:0] halt_v;

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
        // Hold the compare value and action bits of this register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q[g] <= '0;
                act_q[g] <= '0;
            end else begin
                if (val_we[g]) val_q[g] <= wr_val;
                if (act_we[g]) act_q[g] <= wr_act;
            end
        end

        assign hit[g]     = run && (count == val_q[g]);
        assign irq_set[g] = hit[g] && act_q[g].irq;
        assign clr_v[g]   = hit[g] && act_q[g].clr;
        assign halt_v[g]  = hit[g] && act_q[g].halt;
    end

    assign clr_req  = |clr_v;
    assign halt_req = |halt_v;
endmodule

// File: rtl/tmr_capture.sv
// Input-capture channel: synchronizes the pin, detects the chosen edges
// and copies the counter into the capture register. Held off in event mode.
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  cap_cfg_t         cfg,
    input  logic             evt_mode,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capval,
    output logic             cap_set
);
    logic rise;
    logic fall;
    logic load;

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_in),
        .rise (rise),
        .fall (fall)
    );

    // Decide whether the detected edge is one the channel should act on.
    always_comb load = cfg.en && !evt_mode && ((rise && cfg.rise) || (fall && cfg.fall));

    // Copy the counter on a qualifying edge.
    always_ff @(posedge clk) begin
        if (!rst_n) capval <= '0;
        else if (load) capval <= count;
    end

    assign cap_set = load && cfg.ie;
endmodule

// File: rtl/evt_timer.sv
// Top of the match/capture timer: control and status registers, write
// decode, read mux and interrupt output. Assumes DATA_W >= CNT_W and
// NUM_MATCH <= 16 so the compare banks fit the word map.
module evt_timer
    import tmr_pkg::*;
#(
    parameter int NUM_MATCH   = 4,
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_in,
    input  logic              cap_in,
    output logic              irq_o
);
    localparam int FLAG_W = NUM_MATCH + 1;

    logic                            run_q;
    logic                            evt_mode_q;
    cap_cfg_t                        capcfg_q;
    logic [FLAG_W-1:0]               flags_q;
    logic [CNT_W-1:0]                count;
    logic [CNT_W-1:0]                capval;
    logic [NUM_MATCH-1:0][CNT_W-1:0] val_q;
    match_act_t [NUM_MATCH-1:0]      act_q;
    logic [NUM_MATCH-1:0]            irq_set;
    logic                            clr_req;
    logic                            halt_req;
    logic                            cap_set;
    logic                            evt_rise;
    logic                            unused_ev_fall;
    logic                            unused_wr_hi;
    logic                            ctrl_we;
    logic                            capcfg_we;
    logic                            status_we;
    logic [NUM_MATCH-1:0]            val_we;
    logic [NUM_MATCH-1:0]            act_we;

    assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

    assign ctrl_we   = wr_en && (wr_addr == ADDR_W'(A_CTRL));
    assign capcfg_we = wr_en && (wr_addr == ADDR_W'(A_CAPCFG));
    assign status_we = wr_en && (wr_addr == ADDR_W'(A_STATUS));

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_dec
        assign val_we[g] = wr_en && (wr_addr == ADDR_W'(A_MVAL_BASE + g));
        assign act_we[g] = wr_en && (wr_addr == ADDR_W'(A_MACT_BASE + g));
    end

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ev_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ev_in),
        .rise (evt_rise),
        .fall (unused_ev_fall)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .evt_mode(evt_mode_q),
        .evt_rise(evt_rise),
        .clr_req (clr_req),
        .halt_req(halt_req),
        .count   (count)
    );

    tmr_match_bank #(.NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .val_we  (val_we),
        .act_we  (act_we),
        .wr_val  (wr_data[CNT_W-1:0]),
        .wr_act  (match_act_t'(wr_data[2:0])),
        .count   (count),
        .run     (run_q),
        .val_q   (val_q),
        .act_q   (act_q),
        .irq_set (irq_set),
        .clr_req (clr_req),
        .halt_req(halt_req)
    );

    tmr_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_in  (cap_in),
        .cfg     (capcfg_q),
        .evt_mode(evt_mode_q),
        .count   (count),
        .capval  (capval),
        .cap_set (cap_set)
    );

    // Control word: a halting match overrides a same-cycle software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            evt_mode_q <= 1'b0;
        end else begin
            if (ctrl_we) begin
                run_q      <= wr_data[0];
                evt_mode_q <= wr_data[1];
            end
            if (halt_req) run_q <= 1'b0;
        end
    end

    // Capture setup word.
    always_ff @(posedge clk) begin
        if (!rst_n) capcfg_q <= '0;
        else if (capcfg_we) capcfg_q <= cap_cfg_t'(wr_data[3:0]);
    end

    // Sticky flags: write-one clears, a same-cycle set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~(status_we ? wr_data[FLAG_W-1:0] : '0))
                     | {cap_set, irq_set};
        end
    end

    assign irq_o = |flags_q;

    // Read mux over the word map; unmapped words read zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_CTRL))   rd_data[1:0]        = {evt_mode_q, run_q};
        if (rd_addr == ADDR_W'(A_COUNT))  rd_data[CNT_W-1:0]  = count;
        if (rd_addr == ADDR_W'(A_CAPCFG)) rd_data[3:0]        = capcfg_q;
        if (rd_addr == ADDR_W'(A_CAPVAL)) rd_data[CNT_W-1:0]  = capval;
        if (rd_addr == ADDR_W'(A_STATUS)) rd_data[FLAG_W-1:0] = flags_q;
        for (int i = 0; i < NUM_MATCH; i++) begin
            if (rd_addr == ADDR_W'(A_MVAL_BASE + i)) rd_data[CNT_W-1:0] = val_q[i];
            if (rd_addr == ADDR_W'(A_MACT_BASE + i)) rd_data[2:0]       = act_q[i];
        end
    end
endmodule

// File: rtl/evt_timer_chk.sv
// Property checker for evt_timer, attached by bind. Observes the control,
// counter, compare and flag state and checks the match and capture rules.
module evt_timer_chk
    import tmr_pkg::*;
#(
    parameter int NUM_MATCH = 4,
    parameter int CNT_W     = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            run_q,
    input logic                            evt_mode_q,
    input logic [CNT_W-1:0]                count,
    input logic [NUM_MATCH-1:0][CNT_W-1:0] val_q,
    input match_act_t [NUM_MATCH-1:0]      act_q,
    input logic [NUM_MATCH:0]              flags_q,
    input logic [CNT_W-1:0]                capval
);
    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_prop
        a_r3_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && count == val_q[g] && act_q[g].irq) |=> flags_q[g]);
        a_r4_halt_on_match: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && count == val_q[g] && act_q[g].halt) |=> !run_q);
        a_r5_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q && count == val_q[g] && act_q[g].clr) |=> count == '0);
    end

    a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> count == $past(count));

    a_r12_no_capture_event_mode: assert property (@(posedge clk) disable iff (!rst_n)
        evt_mode_q |=> capval == $past(capval));
endmodule

bind evt_timer evt_timer_chk #(.NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_q     (run_q),
    .evt_mode_q(evt_mode_q),
    .count     (count),
    .val_q     (val_q),
    .act_q     (act_q),
    .flags_q   (flags_q),
    .capval    (capval)
);

// File: tb/sim_evt_timer.sv
// Self-checking bench for evt_timer: a table of match scenarios followed by
// directed reset, register, event-mode and capture tests. 50 MHz clock.
module sim_evt_timer;
    localparam logic [5:0] AD_CTRL = 6'h00, AD_COUNT = 6'h01, AD_CAPCFG = 6'h02,
                           AD_CAPVAL = 6'h03, AD_STATUS = 6'h04,
                           AD_MV0 = 6'h10, AD_MV1 = 6'h11, AD_MV2 = 6'h12,
                           AD_MA0 = 6'h20, AD_MA1 = 6'h21, AD_MA2 = 6'h22;

    typedef struct packed {
        logic [15:0] mval;
        logic [2:0]  act;
        logic [7:0]  cyc;
        logic [15:0] ecnt;
        logic        eflag;
        logic        erun;
    } vec_t;

    // Compare value, action (bit0 irq, bit1 clear, bit2 halt), cycles after run,
    // expected counter, status bit 0 and run bit.
    localparam vec_t VT [9] = '{
        '{16'd5, 3'd1, 8'd10, 16'd10, 1'b1, 1'b1},
        '{16'd5, 3'd2, 8'd6,  16'd0,  1'b0, 1'b1},
        '{16'd5, 3'd2, 8'd8,  16'd2,  1'b0, 1'b1},
        '{16'd5, 3'd4, 8'd10, 16'd5,  1'b0, 1'b0},
        '{16'd5, 3'd5, 8'd6,  16'd5,  1'b1, 1'b0},
        '{16'd3, 3'd3, 8'd4,  16'd0,  1'b1, 1'b1},
        '{16'd5, 3'd6, 8'd9,  16'd0,  1'b0, 1'b0},
        '{16'd0, 3'd1, 8'd3,  16'd3,  1'b1, 1'b1},
        '{16'd5, 3'd2, 8'd5,  16'd5,  1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ev_in = 1'b0;
    logic        cap_in = 1'b0;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    evt_timer u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .ev_in  (ev_in),
        .cap_in (cap_in),
        .irq_o  (irq_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ev_in = 1'b0;
        cap_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ev_pulse();
        @(negedge clk);
        ev_in = 1'b1;
        repeat (3) @(negedge clk);
        ev_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Drive cap_in, then read the counter in the detection cycle and the
    // capture value one edge later.
    task automatic cap_step(input logic v, output logic [31:0] cnt_at, output logic [31:0] capv);
        @(negedge clk);
        cap_in = v;
        @(negedge clk);
        @(negedge clk);
        rd(AD_COUNT, cnt_at);
        @(negedge clk);
        rd(AD_CAPVAL, capv);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] c;
        logic [31:0] v;
        logic [31:0] prev;

        // R1 reset state
        do_reset();
        @(negedge clk);
        rd(AD_COUNT, d);  chk("R1 count", d, 0);
        rd(AD_STATUS, d); chk("R1 status", d, 0);
        rd(AD_CTRL, d);   chk("R1 ctrl", d, 0);
        rd(AD_CAPCFG, d); chk("R1 capcfg", d, 0);
        rd(AD_CAPVAL, d); chk("R1 capval", d, 0);
        rd(AD_MV0, d);    chk("R1 compare value", d, 0);
        rd(AD_MA0, d);    chk("R1 compare action", d, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);

        // R2 upper half of a compare word is dropped
        wr(AD_MV0, 32'hABCD_1234);
        rd(AD_MV0, d); chk("R2 compare upper bits", d, 32'h0000_1234);

        // R13 read-only words ignore writes
        wr(AD_COUNT, 32'h55);
        rd(AD_COUNT, d); chk("R13 count write ignored", d, 0);
        wr(AD_CAPVAL, 32'h77);
        rd(AD_CAPVAL, d); chk("R13 capval write ignored", d, 0);

        // Table of single-compare scenarios (R3, R4, R5, R7)
        for (int i = 0; i < 9; i++) begin
            do_reset();
            wr(AD_MV0, {16'd0, VT[i].mval});
            wr(AD_MA0, {29'd0, VT[i].act});
            wr(AD_CTRL, 32'h1);
            repeat (int'(VT[i].cyc)) @(negedge clk);
            rd(AD_COUNT, d);  chk($sformatf("R5/R7 table %0d count", i), d, {16'd0, VT[i].ecnt});
            rd(AD_STATUS, d); chk($sformatf("R3 table %0d flag", i), d, {31'd0, VT[i].eflag});
            chk($sformatf("R3 table %0d irq", i), {31'd0, irq_o}, {31'd0, VT[i].eflag});
            rd(AD_CTRL, d);   chk($sformatf("R4 table %0d run", i), d, {31'd0, VT[i].erun});
        end

        // R6 two compares hit together: interrupt from one, halt from the other
        do_reset();
        wr(AD_MV0, 32'd4); wr(AD_MA0, 32'd1);
        wr(AD_MV1, 32'd4); wr(AD_MA1, 32'd4);
        wr(AD_MV2, 32'd9); wr(AD_MA2, 32'd1);
        wr(AD_CTRL, 32'h1);
        repeat (7) @(negedge clk);
        rd(AD_COUNT, d);  chk("R6 count held", d, 4);
        rd(AD_CTRL, d);   chk("R6 stopped", d, 0);
        rd(AD_STATUS, d); chk("R6 flag", d, 1);

        // R11 write-one clear with no competing set
        wr(AD_STATUS, 32'h1);
        rd(AD_STATUS, d); chk("R11 clear", d, 0);
        chk("R11 irq low", {31'd0, irq_o}, 0);

        // R11 set wins: event mode parks the counter on a matching value
        do_reset();
        wr(AD_MV0, 32'd0); wr(AD_MA0, 32'd1);
        wr(AD_CTRL, 32'h3);
        repeat (3) @(negedge clk);
        wr(AD_STATUS, 32'h1);
        rd(AD_STATUS, d); chk("R11 set wins", d, 1);

        // R7 event mode counts input edges, not clocks
        repeat (5) @(negedge clk);
        rd(AD_COUNT, d); chk("R7 event idle", d, 0);
        ev_pulse(); ev_pulse(); ev_pulse();
        rd(AD_COUNT, d); chk("R7 event count", d, 3);

        // R12 no capture in event mode even with all setup bits on
        wr(AD_CAPCFG, 32'hF);
        cap_step(1'b1, c, v);
        cap_step(1'b0, c, v);
        chk("R12 capval", v, 0);
        rd(AD_STATUS, d); chk("R12 capture flag", d & 32'h10, 0);

        // Capture in clock mode
        do_reset();
        wr(AD_CAPCFG, 32'h9);
        wr(AD_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        cap_step(1'b1, c, v);
        chk("R8 rising capture", v, c);
        prev = v;
        cap_step(1'b0, c, v);
        chk("R8 falling ignored", v, prev);
        rd(AD_STATUS, d); chk("R10 no flag without enable", d, 0);

        wr(AD_CAPCFG, 32'hE);
        cap_step(1'b1, c, v);
        chk("R8 rising ignored", v, prev);
        cap_step(1'b0, c, v);
        chk("R8 falling capture", v, c);
        rd(AD_STATUS, d); chk("R10 capture flag", d, 32'h10);
        chk("R10 irq", {31'd0, irq_o}, 1);
        wr(AD_STATUS, 32'h10);
        rd(AD_STATUS, d); chk("R11 capture flag clear", d, 0);

        wr(AD_CAPCFG, 32'hB);
        cap_step(1'b1, c, v);
        chk("R8 both rising", v, c);
        cap_step(1'b0, c, v);
        chk("R8 both falling", v, c);
        prev = v;

        wr(AD_CAPCFG, 32'h7);
        cap_step(1'b1, c, v);
        chk("R9 disabled no load", v, prev);
        rd(AD_STATUS, d); chk("R9 disabled no flag", d, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule